// File: doc/BRIEF.md
# Linear CCD Sensor Timing Sequencer

This block produces every timing signal a linear CCD image sensor needs from one fast system clock. It divides the system clock down to a free-running master clock with a 50% duty cycle. On each capture it drops the integration clear gate, pulses the shift gate inside that low window, and then releases the clear gate exactly as a master clock high phase begins. That release starts the pixel readout. From that moment the block issues one sample strobe to an external ADC every two master clock periods. It counts out the whole frame, dummy pixels included, and tags every strobe with a pixel index and an image-data flag.

A free-running microsecond counter timestamps two events: the start of each integration period (the shift gate falling edge) and the start of each readout (the clear gate rising edge). When a readout completes, the next gate sequence is held back until a programmable minimum integration time has run from the last integration start. After reset the block runs two full flush frames with strobes suppressed. It then waits for the run enable before it captures continuously.

Top module: `ccd_sequencer`

## Requirements
- R1: While reset is asserted the clear gate is at its idle high level, the shift gate is at its idle low level, and neither a sample strobe nor a frame-done pulse is driven.
- R2: The master clock is high for MCLK_HALF system cycles and low for MCLK_HALF system cycles, repeating without pause. With the defaults its frequency (SYS_CLK_KHZ / (2*MCLK_HALF)) lies between 0.4 MHz and 4 MHz.
- R3: A gate sequence runs in a fixed order. The clear gate falls. Exactly ICG_LEAD_CYC cycles later the shift gate rises. It stays high for exactly SH_HIGH_CYC cycles (more than 1000 ns) and then falls. The clear gate rises between SH_TAIL_CYC+1 and SH_TAIL_CYC+2*MCLK_HALF cycles after that (more than 1000 ns). The shift gate is never high while the clear gate is high.
- R4: The clear gate rises in the same system cycle in which the master clock rises.
- R5: In a normal frame the first sample strobe falls in the cycle of the clear gate rise. Strobes then follow every 4*MCLK_HALF cycles, each on a master clock rise. The pixel index counts 0, 1, 2, ... and reaches 1545, for 1546 strobes per frame.
- R6: pixelValid is high only together with a strobe, and exactly for indices 32 through 1531.
- R7: frameDone pulses for one cycle, in the cycle right after the strobe of index 1545, and at no other time.
- R8: intStartTs shows the microsecond count of the cycle before the shift gate fell, from that fall on. readStartTs shows the microsecond count of the cycle before the clear gate rose, from that rise on. The microsecond count advances once per SYS_CLK_KHZ/1000 cycles from zero at reset.
- R9: After a normal readout ends the next clear gate fall waits until the elapsed microseconds since the last integration start reach minIntUs. If that time has already passed it follows one cycle after the readout.
- R10: After reset two complete gate-and-readout frames run back to back, whatever the run enable, and neither issues strobes or frame-done.
- R11: Once flushing is over, no new gate sequence starts while runEn is low. A frame in progress completes.
- R12: With INVERT set, the master clock, clear gate and shift gate outputs are the exact complements of the non-inverted block's outputs. The sample outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Allow continuous capture after flushing |
| minIntUs | input | TS_W (32) | Minimum integration time in microseconds |
| mclkOut | output | 1 | Sensor master clock |
| icgOut | output | 1 | Integration clear gate |
| shOut | output | 1 | Shift gate |
| sampleStrobe | output | 1 | One-cycle ADC sample trigger |
| pixelIndex | output | IDX_W (11) | Index of the pixel being shifted out |
| pixelValid | output | 1 | Strobe belongs to an image pixel |
| frameDone | output | 1 | Pulse after the last strobe of a frame |
| intStartTs | output | TS_W (32) | Microsecond stamp of the last integration start |
| readStartTs | output | TS_W (32) | Microsecond stamp of the last readout start |

## Verification
The hardest case to reach from the ports is the minimum-integration gate landing on exactly the right cycle. The elapsed count crosses minIntUs only on a microsecond boundary, and that must fall after a readout whose start was itself aligned to a master clock edge. The stimulus draws a fresh minIntUs at each readout start from a seeded random source, mixed with a directed zero value and a directed long value. The bench then requires the clear gate fall to be the first cycle in which the elapsed time is enough. Flush frames, an idle stretch with the run enable low, and a run enable dropped mid-frame cover the start-up and stop paths.

// File: rtl/ccd_seq_pkg.sv
`timescale 1ns/1ps
package ccd_seq_pkg;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic runPix;    // readout in progress
    logic clearPix;  // restart pixel counting (clear gate release next cycle)
    logic sampleEn;  // strobes permitted (not flushing)
    logic capInt;    // record integration start stamp
    logic capRead;   // record readout start stamp
  } seqCtl_t;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_ICG_LEAD,
    ST_SH_HIGH,
    ST_SH_TAIL,
    ST_ALIGN,
    ST_READ
  } seqState_t;

endpackage

// File: rtl/ccd_seq_ctrl.sv
`timescale 1ns/1ps
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int ICG_LEAD_CYC = 4,
  parameter int SH_HIGH_CYC  = 20,
  parameter int SH_TAIL_CYC  = 20,
  parameter int FLUSH_FRAMES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    runEn,
  input  logic    periodEnd,
  input  logic    readDone,
  input  logic    intPending,
  output seqCtl_t ctl,
  output logic    icgLow,
  output logic    shHigh
);

  localparam int MAX_DLY = (ICG_LEAD_CYC > SH_HIGH_CYC)
                         ? ((ICG_LEAD_CYC > SH_TAIL_CYC) ? ICG_LEAD_CYC : SH_TAIL_CYC)
                         : ((SH_HIGH_CYC > SH_TAIL_CYC) ? SH_HIGH_CYC : SH_TAIL_CYC);
  localparam int DLY_W   = $clog2(MAX_DLY + 1);
  localparam int FL_W    = $clog2(FLUSH_FRAMES + 1);

  seqState_t        state;
  logic [DLY_W-1:0] dly;
  logic [FL_W-1:0]  flushLeft;
  logic             flushing;
  logic             leadDone, highDone, tailDone;

  assign flushing = (flushLeft != '0);
  assign leadDone = (dly == DLY_W'(ICG_LEAD_CYC - 1));
  assign highDone = (dly == DLY_W'(SH_HIGH_CYC - 1));
  assign tailDone = (dly == DLY_W'(SH_TAIL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HOLD;
      dly       <= '0;
      flushLeft <= FL_W'(FLUSH_FRAMES);
    end else begin
      case (state)
        ST_HOLD: begin
          dly <= '0;
          if (flushing || (runEn && !intPending)) state <= ST_ICG_LEAD;
        end
        ST_ICG_LEAD: begin
          if (leadDone) begin
            state <= ST_SH_HIGH;
            dly   <= '0;
          end else dly <= dly + 1'b1;
        end
        ST_SH_HIGH: begin
          if (highDone) begin
            state <= ST_SH_TAIL;
            dly   <= '0;
          end else dly <= dly + 1'b1;
        end
        ST_SH_TAIL: begin
          if (tailDone) begin
            state <= ST_ALIGN;
            dly   <= '0;
          end else dly <= dly + 1'b1;
        end
        ST_ALIGN: begin
          if (periodEnd) state <= ST_READ;
        end
        ST_READ: begin
          if (readDone) begin
            state <= ST_HOLD;
            if (flushing) flushLeft <= flushLeft - 1'b1;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.runPix   = (state == ST_READ);
    ctl.clearPix = (state == ST_ALIGN) && periodEnd;
    ctl.capRead  = (state == ST_ALIGN) && periodEnd;
    ctl.capInt   = (state == ST_SH_HIGH) && highDone;
    ctl.sampleEn = !flushing;
  end

  assign icgLow = (state == ST_ICG_LEAD) || (state == ST_SH_HIGH) ||
                  (state == ST_SH_TAIL)  || (state == ST_ALIGN);
  assign shHigh = (state == ST_SH_HIGH);

endmodule

// File: rtl/ccd_seq_dp.sv
`timescale 1ns/1ps
module ccd_seq_dp
  import ccd_seq_pkg::*;
#(
  parameter int SYS_CLK_KHZ = 16000,
  parameter int MCLK_HALF   = 2,
  parameter int LEAD_DUMMY  = 32,
  parameter int IMAGE_PIX   = 1500,
  parameter int FRAME_PIX   = 1546,
  parameter int IDX_W       = 11,
  parameter int TS_W        = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqCtl_t          ctl,
  input  logic [TS_W-1:0]  minIntUs,
  output logic             mclkHigh,
  output logic             periodEnd,
  output logic             readDone,
  output logic             intPending,
  output logic             sampleStrobe,
  output logic             pixelValid,
  output logic             frameDone,
  output logic [IDX_W-1:0] pixelIndex,
  output logic [TS_W-1:0]  intStartTs,
  output logic [TS_W-1:0]  readStartTs
);

  localparam int PERIOD   = 2 * MCLK_HALF;
  localparam int CNT_W    = $clog2(PERIOD);
  localparam int US_DIV   = SYS_CLK_KHZ / 1000;
  localparam int PRE_W    = $clog2(US_DIV + 1);
  localparam int LAST_IDX = FRAME_PIX - 1;
  localparam int IMG_END  = LEAD_DUMMY + IMAGE_PIX;

  logic [CNT_W-1:0] mCnt;
  logic [PRE_W-1:0] preCnt;
  logic [TS_W-1:0]  usCount;
  logic             pixPhase;
  logic [IDX_W-1:0] idx;
  logic             atLast;
  logic             periodStart;

  // master clock divider: high for the first half of each period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mCnt <= '0;
    else if (periodEnd) mCnt <= '0;
    else mCnt <= mCnt + 1'b1;
  end

  assign periodEnd   = (mCnt == CNT_W'(PERIOD - 1));
  assign periodStart = (mCnt == '0);
  assign mclkHigh    = (mCnt < CNT_W'(MCLK_HALF));

  // microsecond time base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (preCnt == PRE_W'(US_DIV - 1)) begin
      preCnt  <= '0;
      usCount <= usCount + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intStartTs  <= '0;
      readStartTs <= '0;
    end else begin
      if (ctl.capInt)  intStartTs  <= usCount;
      if (ctl.capRead) readStartTs <= usCount;
    end
  end

  assign intPending = ((usCount - intStartTs) < minIntUs);

  // pixel counting: two master clock periods per pixel
  assign atLast = (idx == IDX_W'(LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pixPhase <= 1'b0;
      idx      <= '0;
    end else if (ctl.clearPix) begin
      pixPhase <= 1'b0;
      idx      <= '0;
    end else if (ctl.runPix && periodEnd) begin
      pixPhase <= ~pixPhase;
      if (pixPhase && !atLast) idx <= idx + 1'b1;
    end
  end

  assign readDone     = ctl.runPix && periodEnd && pixPhase && atLast;
  assign sampleStrobe = ctl.runPix && ctl.sampleEn && periodStart && !pixPhase;
  assign pixelValid   = sampleStrobe && (idx >= IDX_W'(LEAD_DUMMY)) &&
                        (idx < IDX_W'(IMG_END));
  assign pixelIndex   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frameDone <= 1'b0;
    else frameDone <= sampleStrobe && atLast;
  end

endmodule

// File: rtl/ccd_sequencer.sv
`timescale 1ns/1ps
module ccd_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int INVERT       = 0,
  parameter int SYS_CLK_KHZ  = 16000,
  parameter int MCLK_HALF    = 2,
  parameter int ICG_LEAD_CYC = 4,
  parameter int SH_HIGH_CYC  = 20,
  parameter int SH_TAIL_CYC  = 20,
  parameter int LEAD_DUMMY   = 32,
  parameter int IMAGE_PIX    = 1500,
  parameter int TRAIL_DUMMY  = 14,
  parameter int FLUSH_FRAMES = 2,
  parameter int TS_W         = 32,
  localparam int FRAME_PIX   = LEAD_DUMMY + IMAGE_PIX + TRAIL_DUMMY,
  localparam int IDX_W       = $clog2(FRAME_PIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             runEn,
  input  logic [TS_W-1:0]  minIntUs,
  output logic             mclkOut,
  output logic             icgOut,
  output logic             shOut,
  output logic             sampleStrobe,
  output logic [IDX_W-1:0] pixelIndex,
  output logic             pixelValid,
  output logic             frameDone,
  output logic [TS_W-1:0]  intStartTs,
  output logic [TS_W-1:0]  readStartTs
);

  seqCtl_t ctl;
  logic    periodEnd, readDone, intPending;
  logic    mclkHigh, icgLow, shHigh;

  ccd_seq_ctrl #(
    .ICG_LEAD_CYC (ICG_LEAD_CYC),
    .SH_HIGH_CYC  (SH_HIGH_CYC),
    .SH_TAIL_CYC  (SH_TAIL_CYC),
    .FLUSH_FRAMES (FLUSH_FRAMES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .runEn      (runEn),
    .periodEnd  (periodEnd),
    .readDone   (readDone),
    .intPending (intPending),
    .ctl        (ctl),
    .icgLow     (icgLow),
    .shHigh     (shHigh)
  );

  ccd_seq_dp #(
    .SYS_CLK_KHZ (SYS_CLK_KHZ),
    .MCLK_HALF   (MCLK_HALF),
    .LEAD_DUMMY  (LEAD_DUMMY),
    .IMAGE_PIX   (IMAGE_PIX),
    .FRAME_PIX   (FRAME_PIX),
    .IDX_W       (IDX_W),
    .TS_W        (TS_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .minIntUs     (minIntUs),
    .mclkHigh     (mclkHigh),
    .periodEnd    (periodEnd),
    .readDone     (readDone),
    .intPending   (intPending),
    .sampleStrobe (sampleStrobe),
    .pixelValid   (pixelValid),
    .frameDone    (frameDone),
    .pixelIndex   (pixelIndex),
    .intStartTs   (intStartTs),
    .readStartTs  (readStartTs)
  );

  // output polarity chosen at build time for external inverting buffers
  generate
    if (INVERT != 0) begin : g_inv
      assign mclkOut = ~mclkHigh;
      assign icgOut  = icgLow;
      assign shOut   = ~shHigh;
    end else begin : g_true
      assign mclkOut = mclkHigh;
      assign icgOut  = ~icgLow;
      assign shOut   = shHigh;
    end
  endgenerate

endmodule

// File: rtl/ccd_seq_chk.sv
`timescale 1ns/1ps
module ccd_seq_chk #(
  parameter int INVERT      = 0,
  parameter int SYS_CLK_KHZ = 16000,
  parameter int LEAD_DUMMY  = 32,
  parameter int IMAGE_PIX   = 1500,
  parameter int FRAME_PIX   = 1546,
  parameter int IDX_W       = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mclkOut,
  input logic             icgOut,
  input logic             shOut,
  input logic             sampleStrobe,
  input logic [IDX_W-1:0] pixelIndex,
  input logic             pixelValid,
  input logic             frameDone
);

  localparam logic POL      = (INVERT != 0);
  localparam int   SH_MIN   = SYS_CLK_KHZ / 1000 + 1;              // > 1000 ns
  localparam int   LEAD_MIN = (SYS_CLK_KHZ / 10 + 999) / 1000;     // >= 100 ns
  localparam int   LEAD_MAX = SYS_CLK_KHZ / 1000;                  // <= 1000 ns
  localparam int   PER_MIN  = SYS_CLK_KHZ / 4000;                  // <= 4 MHz
  localparam int   PER_MAX  = SYS_CLK_KHZ / 400;                   // >= 0.4 MHz

  logic mclkA, icgHighA, shA;
  assign mclkA    = mclkOut ^ POL;
  assign icgHighA = icgOut ^ POL;
  assign shA      = shOut ^ POL;

  logic [15:0] shRun, leadRun, tailRun, perCnt;
  logic        prevM, seenRise, mRise;
  assign mRise = mclkA && !prevM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shRun <= '0; leadRun <= '0; tailRun <= '0; perCnt <= '0;
      prevM <= 1'b1; seenRise <= 1'b0;
    end else begin
      shRun    <= shA ? shRun + 1'b1 : '0;
      leadRun  <= (!icgHighA && !shA) ? leadRun + 1'b1 : '0;
      tailRun  <= (!icgHighA && !shA) ? tailRun + 1'b1 : '0;
      perCnt   <= mRise ? 16'd1 : perCnt + 1'b1;
      prevM    <= mclkA;
      seenRise <= seenRise | mRise;
    end
  end

  AST_ICG_ON_MCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(icgHighA) |-> $rose(mclkA)); // R4

  AST_SH_INSIDE_ICG: assert property (@(posedge clk) disable iff (!rst_n)
    shA |-> !icgHighA); // R3

  AST_SH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shA) |-> (shRun >= 16'(SH_MIN))); // R3

  AST_ICG_LEAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shA) |-> (leadRun >= 16'(LEAD_MIN) && leadRun <= 16'(LEAD_MAX))); // R3

  AST_SH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(icgHighA) |-> (tailRun >= 16'(SH_MIN))); // R3

  AST_STROBE_ON_MCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    sampleStrobe |-> $rose(mclkA)); // R5

  AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pixelValid |-> (sampleStrobe && pixelIndex >= IDX_W'(LEAD_DUMMY) &&
                    pixelIndex < IDX_W'(LEAD_DUMMY + IMAGE_PIX))); // R6

  AST_FRAME_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> $past(sampleStrobe && pixelIndex == IDX_W'(FRAME_PIX - 1))); // R7

  AST_MCLK_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mRise && seenRise) |-> (perCnt >= 16'(PER_MIN) && perCnt <= 16'(PER_MAX))); // R2

endmodule

bind ccd_sequencer ccd_seq_chk #(
  .INVERT      (INVERT),
  .SYS_CLK_KHZ (SYS_CLK_KHZ),
  .LEAD_DUMMY  (LEAD_DUMMY),
  .IMAGE_PIX   (IMAGE_PIX),
  .FRAME_PIX   (FRAME_PIX),
  .IDX_W       (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mclkOut      (mclkOut),
  .icgOut       (icgOut),
  .shOut        (shOut),
  .sampleStrobe (sampleStrobe),
  .pixelIndex   (pixelIndex),
  .pixelValid   (pixelValid),
  .frameDone    (frameDone)
);

// File: tb/ccd_sequencer_bench.sv
`timescale 1ns/1ps
module ccd_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T     = 16;        // system cycles per microsecond
  localparam int H     = 2;         // master clock half period
  localparam int P     = 2 * H;
  localparam int PIX   = 2 * P;     // cycles per pixel
  localparam int NPIX  = 1546;
  localparam int LEAD  = 4;
  localparam int SHHI  = 20;
  localparam int TAIL  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        runEn = 1'b0;
  logic [31:0] minIntUs = '0;

  logic        mclk, icg, sh, strobe, valid, fdone;
  logic [10:0] pixIdx;
  logic [31:0] intTs, readTs;
  logic        mclkI, icgI, shI, strobeI, validI, fdoneI;
  logic [10:0] pixIdxI;
  logic [31:0] intTsI, readTsI;

  ccd_sequencer u_ccd_sequencer (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .minIntUs(minIntUs),
    .mclkOut(mclk), .icgOut(icg), .shOut(sh), .sampleStrobe(strobe),
    .pixelIndex(pixIdx), .pixelValid(valid), .frameDone(fdone),
    .intStartTs(intTs), .readStartTs(readTs)
  );

  ccd_sequencer #(.INVERT(1)) u_ccd_sequencer_inv (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .minIntUs(minIntUs),
    .mclkOut(mclkI), .icgOut(icgI), .shOut(shI), .sampleStrobe(strobeI),
    .pixelIndex(pixIdxI), .pixelValid(validI), .frameDone(fdoneI),
    .intStartTs(intTsI), .readStartTs(readTsI)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int usAt(input int c);
    return c / T;
  endfunction

  // monitor state
  int  cyc = 0;
  bit  prevM = 1'b1, prevIcg = 1'b1, prevSh = 1'b0;
  bit  seenEdge = 1'b0;
  int  runLen = 0;
  int  icgFallC = 0, shRiseC = 0, shFallC = 0, icgRiseC = 0;
  int  holdC = 1 << 30;
  int  icgRises = 0;
  int  expIdx = 0, strobesInFrame = 0;
  bit  flushFrame = 1'b1;
  bit  prevLastStrobe = 1'b0;
  bit  afterReadout = 1'b0;
  bit  runPrev = 1'b0;
  int  minPrev = 0;
  int  expIntTs = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      // R12: polarity variant
      check(mclkI == ~mclk && icgI == ~icg && shI == ~sh && strobeI == strobe &&
            pixIdxI == pixIdx && fdoneI == fdone, "R12", "inverted outputs",
            {mclkI, icgI, shI}, {~mclk, ~icg, ~sh});

      // R2: master clock half periods
      if (mclk == prevM) runLen++;
      else begin
        if (seenEdge) check(runLen == H, "R2", "mclk half period", runLen, H);
        runLen = 1;
        seenEdge = 1'b1;
      end

      if (!runEn) afterReadout = 1'b0;
      if (cyc == holdC) afterReadout = runEn;

      // clear gate falls
      if (prevIcg && !icg) begin
        if (icgRises == 0) check(cyc == 1, "R10", "first flush start", cyc, 1);
        else if (icgRises == 1) check(cyc == holdC + 1, "R10", "second flush start", cyc, holdC + 1);
        else begin
          check(runPrev, "R11", "sequence start needs runEn", runPrev, 1);
          if (!flushFrame)
            check(strobesInFrame == NPIX, "R5", "strobes in frame", strobesInFrame, NPIX);
          if (afterReadout) begin
            check(usAt(cyc - 1) - expIntTs >= minPrev, "R9", "elapsed at start",
                  usAt(cyc - 1) - expIntTs, minPrev);
            if (cyc != holdC + 1)
              check(usAt(cyc - 2) - expIntTs < minPrev, "R9", "start delayed too long",
                    usAt(cyc - 2) - expIntTs, minPrev);
          end
        end
        icgFallC = cyc;
      end

      if (!prevSh && sh) begin
        check(cyc - icgFallC == LEAD, "R3", "clear-to-shift lead", cyc - icgFallC, LEAD);
        check(!icg, "R3", "clear gate low at shift rise", icg, 0);
        shRiseC = cyc;
      end

      if (prevSh && !sh) begin
        check(cyc - shRiseC == SHHI, "R3", "shift pulse width", cyc - shRiseC, SHHI);
        expIntTs = usAt(cyc - 1);
        check(intTs == expIntTs, "R8", "integration stamp", intTs, expIntTs);
        shFallC = cyc;
      end

      if (!prevIcg && icg) begin
        check(cyc - shFallC >= TAIL + 1 && cyc - shFallC <= TAIL + P, "R3",
              "shift-to-release gap", cyc - shFallC, TAIL + 1);
        check(mclk && !prevM, "R4", "release on mclk rise", {prevM, mclk}, 2'b01);
        check(readTs == usAt(cyc - 1), "R8", "readout stamp", readTs, usAt(cyc - 1));
        icgRises++;
        icgRiseC = cyc;
        holdC = cyc + NPIX * PIX;
        expIdx = 0;
        strobesInFrame = 0;
        flushFrame = (icgRises <= 2);
        if (!flushFrame) check(strobe, "R5", "first strobe at release", strobe, 1);
      end

      if (strobe) begin
        if (flushFrame) check(1'b0, "R10", "strobe during flush", 1, 0);
        else begin
          check((cyc - icgRiseC) % PIX == 0 && pixIdx == expIdx, "R5",
                "strobe index", pixIdx, expIdx);
          check(valid == (expIdx >= 32 && expIdx <= 1531), "R6", "valid flag",
                valid, (expIdx >= 32 && expIdx <= 1531));
        end
        expIdx++;
        strobesInFrame++;
      end

      if (prevLastStrobe || fdone)
        check(fdone == prevLastStrobe, "R7", "frame done timing", fdone, prevLastStrobe);
      prevLastStrobe = strobe && (pixIdx == 11'(NPIX - 1));

      prevM   = mclk;
      prevIcg = icg;
      prevSh  = sh;
      runPrev = runEn;
      minPrev = int'(minIntUs);
    end
  end

  task automatic waitRises(input int n);
    while (icgRises < n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (4) @(negedge clk);
    // R1: idle levels in reset
    check(icg == 1'b1, "R1", "clear gate idle", icg, 1);
    check(sh == 1'b0, "R1", "shift gate idle", sh, 0);
    check(!strobe && !fdone, "R1", "no strobe in reset", {strobe, fdone}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R10: flush frames run with runEn low
    waitRises(2);
    while (cyc <= holdC + 2) @(negedge clk);
    // R11: stays idle with runEn low
    repeat (1500) @(negedge clk);
    check(icg && !sh && icgRises == 2, "R11", "idle after flush", icgRises, 2);

    @(posedge clk); #1 runEn = 1'b1;
    for (int f = 0; f < 5; f++) begin
      waitRises(3 + f);
      @(posedge clk); #1;
      if (f == 0) minIntUs = 32'd0;              // immediate restart
      else if (f == 1) minIntUs = 32'd1100;      // long hold
      else minIntUs = $urandom_range(0, 1000);
    end
    // drop runEn mid-frame: frame completes, nothing follows
    @(posedge clk); #1 runEn = 1'b0;
    while (cyc <= holdC + 3000) @(negedge clk);
    check(icgRises == 7 && icg, "R11", "no start after runEn drop", icgRises, 7);
    check(strobesInFrame == NPIX, "R5", "last frame strobe count", strobesInFrame, NPIX);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule